// File: doc/BRIEF.md
# Arithmetic Status Flags Register

This block keeps the condition-code register of an integer datapath. Each cycle the execution stage may hand it an operation class, an operand size, both source operands and the result that the arithmetic unit already produced. From those the block derives the new carry, parity, auxiliary carry, zero, sign and overflow flags, following rules that depend on the class of the operation and the width of the operands. No second adder is needed: every flag comes from operand and result bits at the relevant boundary.

Besides those updates, the block accepts short flag commands and a whole-register load. The flag commands set, clear or invert carry, and set or clear the direction bit. The whole-register load restores a saved image. The register is always visible as a 64-bit word with fixed flag positions. Bit 1 is a constant one and every other non-flag bit is a constant zero. All updates land on the clock edge after the inputs are presented.

Top module: `flag_reg_unit`

## Requirements
- R1: While rstN is low, and on the first edge after it rises, flagsOut reads 64'h2: all seven flags are zero and bit 1 is one.
- R2: Carry sits at bit 0, parity at bit 2, auxiliary carry at bit 4, zero at bit 6, sign at bit 7, direction at bit 10 and overflow at bit 11. Bit 1 always reads one. Bits 63..32 and every other bit read zero, and whatever is written to them is discarded.
- R3: With wrEn high, the seven flags take the matching bits of wrData on the next edge. This load overrides any flag command and any operation in the same cycle.
- R4: flagCmd codes are 1 set carry, 2 clear carry, 3 invert carry, 4 set direction and 5 clear direction. Codes 0, 6 and 7 do nothing. A command changes only its own flag and overrides an operation presented in the same cycle.
- R5: opClass codes are 0 add, 1 subtract, 2 increment, 3 decrement, 4 logical, 5 compare, 6 shift/rotate and 7 bit test. opSize codes 0/1/2/3 select 8/16/32/64 bits. For add, carry is the carry out of the selected size's top bit. For subtract and compare (opResult = srcA - srcB), carry is the borrow out of that bit.
- R6: Increment and decrement (step given on srcB) leave carry unchanged. They update parity, auxiliary carry, zero, sign and overflow as add and subtract do.
- R7: A logical operation clears carry, overflow and auxiliary carry, and sets parity, zero and sign from opResult.
- R8: For every class except bit test, parity is one exactly when opResult[7:0] holds an even number of one bits, whatever the operand size.
- R9: Auxiliary carry is the carry (add, increment) or the borrow (subtract, decrement, compare) out of bit 3.
- R10: Zero is set when opResult is zero within the selected size. Sign equals opResult bit 7, 15, 31 or 63 for the selected size.
- R11: For add and increment, overflow is set when the true signed sum of the size-truncated operands falls outside the signed range of the size. For subtract, decrement and compare, the same test is applied to the signed difference.
- R12: A shift takes carry from shiftOut and updates parity, zero and sign. Auxiliary carry is kept. If shiftMulti is low, overflow becomes opResult's top bit XOR srcA's top bit. If shiftMulti is high, overflow is kept.
- R13: A bit test copies srcA bit (srcB mod size) into carry and leaves every other flag unchanged.
- R14: With opValid low, wrEn low and flagCmd 0, the register holds its value whatever the data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An operation's flags are to be taken this cycle |
| opClass | input | 3 | Operation class code |
| opSize | input | 2 | Operand size code |
| srcA | input | 64 | First source operand |
| srcB | input | 64 | Second source operand, step or bit index |
| opResult | input | 64 | Result produced by the arithmetic unit |
| shiftOut | input | 1 | Last bit shifted out by a shift or rotate |
| shiftMulti | input | 1 | Shift count was larger than one |
| flagCmd | input | 3 | Direct flag command code |
| wrEn | input | 1 | Load the whole register from wrData |
| wrData | input | 64 | Register image to load |
| flagsOut | output | 64 | Current register value |

## Verification
Every result, whether from an operation, a command or a load, is due in flagsOut exactly one rising edge after the inputs are presented, because the seven flag bits are the only state between input and output. The bench changes inputs on a falling edge and compares flagsOut on the following falling edge, so one register stage sits between stimulus and check. Between operations it returns the controls to idle, so a result that arrives a cycle late, or a flag that moves while idle, shows up as a mismatch. Sweeps cover every class at every size with boundary operands (zero, one, all ones, largest positive, most negative) and with random operands. Separate cycles check command priority, load priority and masking of the constant bits.

// File: rtl/flag_pkg.sv
package flag_pkg;

  // bit positions inside the visible register
  localparam int CF_POS  = 0;
  localparam int ONE_POS = 1;
  localparam int PF_POS  = 2;
  localparam int AF_POS  = 4;
  localparam int ZF_POS  = 6;
  localparam int SF_POS  = 7;
  localparam int DF_POS  = 10;
  localparam int OF_POS  = 11;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_INC   = 3'd2,
    OP_DEC   = 3'd3,
    OP_LOGIC = 3'd4,
    OP_CMP   = 3'd5,
    OP_SHIFT = 3'd6,
    OP_BTEST = 3'd7
  } opClass_e;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_STC  = 3'd1,
    CMD_CLC  = 3'd2,
    CMD_CMC  = 3'd3,
    CMD_STD  = 3'd4,
    CMD_CLD  = 3'd5
  } flagCmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAll;
    logic setCarry;
    logic clrCarry;
    logic cplCarry;
    logic setDir;
    logic clrDir;
    logic updCarry;
    logic updPzs;
    logic updAux;
    logic updOvf;
  } strobe_t;

  typedef struct packed {
    logic ovf;
    logic dir;
    logic sign;
    logic zero;
    logic aux;
    logic par;
    logic carry;
  } flagBits_t;

endpackage

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import flag_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [2:0] opClass,
  input  logic [2:0] flagCmd,
  input  logic       wrEn,
  input  logic       shiftMulti,
  output strobe_t    stb
);

  logic cmdHit;

  always_comb begin
    stb    = '0;
    cmdHit = 1'b0;
    if (wrEn) begin
      stb.loadAll = 1'b1;
    end else begin
      cmdHit = 1'b1;
      case (flagCmd_e'(flagCmd))
        CMD_STC: stb.setCarry = 1'b1;
        CMD_CLC: stb.clrCarry = 1'b1;
        CMD_CMC: stb.cplCarry = 1'b1;
        CMD_STD: stb.setDir   = 1'b1;
        CMD_CLD: stb.clrDir   = 1'b1;
        default: cmdHit = 1'b0;
      endcase
      if (!cmdHit && opValid) begin
        case (opClass_e'(opClass))
          OP_ADD, OP_SUB, OP_CMP, OP_LOGIC: begin
            stb.updCarry = 1'b1;
            stb.updPzs   = 1'b1;
            stb.updAux   = 1'b1;
            stb.updOvf   = 1'b1;
          end
          OP_INC, OP_DEC: begin
            stb.updPzs = 1'b1;
            stb.updAux = 1'b1;
            stb.updOvf = 1'b1;
          end
          OP_SHIFT: begin
            stb.updCarry = 1'b1;
            stb.updPzs   = 1'b1;
            stb.updOvf   = !shiftMulti;
          end
          default: stb.updCarry = 1'b1;
        endcase
      end
    end
  end

  // R4
  cmd_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadAll, stb.setCarry, stb.clrCarry, stb.cplCarry, stb.setDir, stb.clrDir}));

  // R3
  load_alone_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadAll |-> !(stb.updCarry || stb.updPzs || stb.updAux || stb.updOvf));

endmodule

// File: rtl/flag_dp.sv
module flag_dp
  import flag_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [2:0]        opClass,
  input  logic [1:0]        opSize,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] opResult,
  input  logic              shiftOut,
  input  logic [DATA_W-1:0] wrData,
  output flagBits_t         cur
);

  localparam int IDX_W = $clog2(DATA_W);

  logic [IDX_W:0]    opBits;
  logic [IDX_W-1:0]  msbIdx;
  logic [IDX_W-1:0]  bitIdx;
  logic [DATA_W-1:0] sizeMask;
  logic              aTop, bTop, rTop;
  logic              isSubLike;
  logic              carryAdd, borrowSub, auxAdd, auxSub, ovfAdd, ovfSub;
  logic              carryNew, auxNew, ovfNew;
  flagBits_t         nxt;
  logic              unusedWr;

  always_comb begin
    case (opSize)
      2'd0:    opBits = (IDX_W+1)'(8);
      2'd1:    opBits = (IDX_W+1)'(16);
      2'd2:    opBits = (IDX_W+1)'(32);
      default: opBits = (IDX_W+1)'(DATA_W);
    endcase
  end

  assign msbIdx   = IDX_W'(opBits - 1'b1);
  assign bitIdx   = srcB[IDX_W-1:0] & msbIdx;
  assign sizeMask = (opBits >= (IDX_W+1)'(DATA_W)) ? '1
                  : ((DATA_W'(1) << opBits) - DATA_W'(1));

  assign aTop = srcA[msbIdx];
  assign bTop = srcB[msbIdx];
  assign rTop = opResult[msbIdx];

  // carry and borrow recovered from the operand and result bits at one boundary
  assign carryAdd  = (aTop & bTop) | ((aTop | bTop) & ~rTop);
  assign borrowSub = (~aTop & bTop) | ((~aTop | bTop) & rTop);
  assign auxAdd    = (srcA[3] & srcB[3]) | ((srcA[3] | srcB[3]) & ~opResult[3]);
  assign auxSub    = (~srcA[3] & srcB[3]) | ((~srcA[3] | srcB[3]) & opResult[3]);
  assign ovfAdd    = (aTop == bTop) && (rTop != aTop);
  assign ovfSub    = (aTop != bTop) && (rTop != aTop);

  assign isSubLike = (opClass_e'(opClass) == OP_SUB) || (opClass_e'(opClass) == OP_DEC)
                  || (opClass_e'(opClass) == OP_CMP);

  always_comb begin
    carryNew = cur.carry;
    auxNew   = cur.aux;
    ovfNew   = cur.ovf;
    case (opClass_e'(opClass))
      OP_ADD, OP_INC, OP_SUB, OP_DEC, OP_CMP: begin
        carryNew = isSubLike ? borrowSub : carryAdd;
        auxNew   = isSubLike ? auxSub : auxAdd;
        ovfNew   = isSubLike ? ovfSub : ovfAdd;
      end
      OP_LOGIC: begin
        carryNew = 1'b0;
        auxNew   = 1'b0;
        ovfNew   = 1'b0;
      end
      OP_SHIFT: begin
        carryNew = shiftOut;
        ovfNew   = rTop ^ aTop;
      end
      default: carryNew = srcA[bitIdx];
    endcase
  end

  always_comb begin
    nxt = cur;
    if (stb.loadAll) begin
      nxt.carry = wrData[CF_POS];
      nxt.par   = wrData[PF_POS];
      nxt.aux   = wrData[AF_POS];
      nxt.zero  = wrData[ZF_POS];
      nxt.sign  = wrData[SF_POS];
      nxt.dir   = wrData[DF_POS];
      nxt.ovf   = wrData[OF_POS];
    end else begin
      if (stb.setCarry) nxt.carry = 1'b1;
      if (stb.clrCarry) nxt.carry = 1'b0;
      if (stb.cplCarry) nxt.carry = ~cur.carry;
      if (stb.setDir)   nxt.dir   = 1'b1;
      if (stb.clrDir)   nxt.dir   = 1'b0;
      if (stb.updCarry) nxt.carry = carryNew;
      if (stb.updAux)   nxt.aux   = auxNew;
      if (stb.updOvf)   nxt.ovf   = ovfNew;
      if (stb.updPzs) begin
        nxt.par  = ~^opResult[7:0];
        nxt.zero = ((opResult & sizeMask) == '0);
        nxt.sign = rTop;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) cur <= '0;
    else       cur <= nxt;
  end

  assign unusedWr = ^{wrData[DATA_W-1:OF_POS+1], wrData[DF_POS-1:SF_POS+1],
                      wrData[ZF_POS-1], wrData[AF_POS-1], wrData[ONE_POS]};

  // R3
  load_takes_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadAll |=> (cur.carry == $past(wrData[CF_POS])) && (cur.ovf == $past(wrData[OF_POS]))
                    && (cur.dir == $past(wrData[DF_POS])));

  // R4
  dir_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.loadAll || stb.setDir || stb.clrDir) |=> (cur.dir == $past(cur.dir)));

endmodule

// File: rtl/flag_reg_unit.sv
module flag_reg_unit
  import flag_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opClass,
  input  logic [1:0]        opSize,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] opResult,
  input  logic              shiftOut,
  input  logic              shiftMulti,
  input  logic [2:0]        flagCmd,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] flagsOut
);

  strobe_t   stb;
  flagBits_t cur;

  flag_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .opValid    (opValid),
    .opClass    (opClass),
    .flagCmd    (flagCmd),
    .wrEn       (wrEn),
    .shiftMulti (shiftMulti),
    .stb        (stb)
  );

  flag_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .opClass  (opClass),
    .opSize   (opSize),
    .srcA     (srcA),
    .srcB     (srcB),
    .opResult (opResult),
    .shiftOut (shiftOut),
    .wrData   (wrData),
    .cur      (cur)
  );

  always_comb begin
    flagsOut          = '0;
    flagsOut[ONE_POS] = 1'b1;
    flagsOut[CF_POS]  = cur.carry;
    flagsOut[PF_POS]  = cur.par;
    flagsOut[AF_POS]  = cur.aux;
    flagsOut[ZF_POS]  = cur.zero;
    flagsOut[SF_POS]  = cur.sign;
    flagsOut[DF_POS]  = cur.dir;
    flagsOut[OF_POS]  = cur.ovf;
  end

  logic quietCtl;
  assign quietCtl = !wrEn && (flagCmd == 3'd0);

  // R6
  incdec_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (quietCtl && opValid && (opClass == 3'd2 || opClass == 3'd3))
    |=> (flagsOut[CF_POS] == $past(flagsOut[CF_POS])));

  // R7
  logic_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (quietCtl && opValid && opClass == 3'd4) |=> (!flagsOut[CF_POS] && !flagsOut[OF_POS]));

  // R4
  cmd_only_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && (flagCmd == 3'd1 || flagCmd == 3'd2 || flagCmd == 3'd3))
    |=> (flagsOut[11:1] == $past(flagsOut[11:1])));

  // R13
  btest_only_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (quietCtl && opValid && opClass == 3'd7) |=> (flagsOut[11:1] == $past(flagsOut[11:1])));

  // R12
  multi_shift_keeps_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (quietCtl && opValid && opClass == 3'd6 && shiftMulti)
    |=> (flagsOut[OF_POS] == $past(flagsOut[OF_POS])) && (flagsOut[AF_POS] == $past(flagsOut[AF_POS])));

  // R14
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (quietCtl && !opValid) |=> $stable(flagsOut));

endmodule

// File: tb/sim_flag_reg_unit.sv
`timescale 1ns/1ps
module sim_flag_reg_unit;

  logic        clk = 1'b0;
  logic        rstN;
  logic        opValid;
  logic [2:0]  opClass;
  logic [1:0]  opSize;
  logic [63:0] srcA, srcB, opResult;
  logic        shiftOut, shiftMulti;
  logic [2:0]  flagCmd;
  logic        wrEn;
  logic [63:0] wrData;
  logic [63:0] flagsOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [63:0] model;

  localparam logic [63:0] FLAG_MASK = 64'h0000_0000_0000_0CD5;

  always #10 clk = ~clk;

  flag_reg_unit u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opClass(opClass), .opSize(opSize),
    .srcA(srcA), .srcB(srcB), .opResult(opResult), .shiftOut(shiftOut),
    .shiftMulti(shiftMulti), .flagCmd(flagCmd), .wrEn(wrEn), .wrData(wrData),
    .flagsOut(flagsOut)
  );

  task automatic check(input string req, input logic [63:0] expv);
    checks++;
    if (flagsOut !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, flagsOut, expv);
    end
  endtask

  task automatic idleCtl();
    opValid = 1'b0; flagCmd = 3'd0; wrEn = 1'b0; shiftMulti = 1'b0;
  endtask

  function automatic logic [63:0] sizeMaskOf(input int w);
    return (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic signed [65:0] sx(input logic [63:0] v, input int w);
    logic [63:0] mm;
    logic [65:0] t;
    mm = sizeMaskOf(w);
    t  = {2'b00, v & mm};
    if (v[w-1]) t = t | ~{2'b00, mm};
    return $signed(t);
  endfunction

  function automatic logic [63:0] predict(input logic [63:0] cur, input int cls, input int size,
      input logic [63:0] a, input logic [63:0] b, input logic [63:0] r,
      input logic so, input logic multi);
    int w;
    logic [63:0] m, nx;
    logic [64:0] sum;
    logic signed [65:0] sres, one, hi, lo;
    logic cy, af, of, pf, zf, sf;
    w   = 8 << size;
    m   = sizeMaskOf(w);
    nx  = cur;
    one = 66'sd1;
    hi  = (one <<< (w-1)) - one;
    lo  = -(one <<< (w-1));
    pf  = ~^r[7:0];
    zf  = ((r & m) == 64'd0);
    sf  = r[w-1];
    cy = 1'b0; af = 1'b0; of = 1'b0;
    if (cls == 0 || cls == 2) begin
      sum  = {1'b0, a & m} + {1'b0, b & m};
      cy   = sum[w];
      af   = ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15;
      sres = sx(a, w) + sx(b, w);
      of   = (sres > hi) || (sres < lo);
    end else if (cls == 1 || cls == 3 || cls == 5) begin
      cy   = (a & m) < (b & m);
      af   = a[3:0] < b[3:0];
      sres = sx(a, w) - sx(b, w);
      of   = (sres > hi) || (sres < lo);
    end
    case (cls)
      0, 1, 5: begin nx[0] = cy; nx[2] = pf; nx[4] = af; nx[6] = zf; nx[7] = sf; nx[11] = of; end
      2, 3:    begin nx[2] = pf; nx[4] = af; nx[6] = zf; nx[7] = sf; nx[11] = of; end
      4:       begin nx[0] = 1'b0; nx[2] = pf; nx[4] = 1'b0; nx[6] = zf; nx[7] = sf; nx[11] = 1'b0; end
      6: begin
        nx[0] = so; nx[2] = pf; nx[6] = zf; nx[7] = sf;
        if (!multi) nx[11] = r[w-1] ^ a[w-1];
      end
      default: nx[0] = a[int'(b[5:0]) & (w-1)];
    endcase
    return nx;
  endfunction

  task automatic runOp(input int cls, input int size, input logic [63:0] a, input logic [63:0] b,
      input logic [63:0] r, input logic so, input logic multi, input string req);
    model      = predict(model, cls, size, a, b, r, so, multi);
    opValid    = 1'b1;
    opClass    = 3'(cls);
    opSize     = 2'(size);
    srcA       = a;
    srcB       = b;
    opResult   = r;
    shiftOut   = so;
    shiftMulti = multi;
    @(negedge clk);
    idleCtl();
    check(req, model);
  endtask

  function automatic logic [63:0] corner(input int k, input logic [63:0] m);
    case (k)
      0: return 64'd0;
      1: return 64'd1;
      2: return m;
      3: return m >> 1;
      4: return (m >> 1) + 64'd1;
      default: return 64'h0F;
    endcase
  endfunction

  function automatic string reqOf(input int cls);
    case (cls)
      0, 1, 5: return "R5 R9 R10 R11";
      2, 3:    return "R6 R9 R11";
      4:       return "R7 R8 R10";
      6:       return "R12";
      default: return "R13";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    idleCtl();
    opClass = 3'd0; opSize = 2'd0; srcA = '0; srcB = '0; opResult = '0;
    shiftOut = 1'b0; wrData = '0;
    model = 64'h2;
    @(negedge clk);
    @(negedge clk);
    check("R1 during reset", 64'h2);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", 64'h2);

    // R3 R2: full load with every bit set; only the seven flags and bit 1 appear
    wrEn = 1'b1; wrData = 64'hFFFF_FFFF_FFFF_FFFF;
    flagCmd = 3'd2; opValid = 1'b1; opClass = 3'd4;
    @(negedge clk);
    idleCtl();
    model = (wrData & FLAG_MASK) | 64'h2;
    check("R2 R3 load all ones", model);
    if (model !== 64'h0CD7) begin
      fails++; checks++;
      $display("FAIL R2 actual=%h expected=%h", model, 64'h0CD7);
    end else checks++;

    // R3: load zeros while garbage sits in upper bits
    wrEn = 1'b1; wrData = 64'hABCD_0000_0000_F328;
    @(negedge clk);
    idleCtl();
    model = (wrData & FLAG_MASK) | 64'h2;
    check("R3 R2 load pattern", model);

    // R4: each command alone
    flagCmd = 3'd1; @(negedge clk); idleCtl(); model[0] = 1'b1;  check("R4 set carry", model);
    flagCmd = 3'd3; @(negedge clk); idleCtl(); model[0] = ~model[0]; check("R4 invert carry", model);
    flagCmd = 3'd3; @(negedge clk); idleCtl(); model[0] = ~model[0]; check("R4 invert carry again", model);
    flagCmd = 3'd2; @(negedge clk); idleCtl(); model[0] = 1'b0;  check("R4 clear carry", model);
    flagCmd = 3'd4; @(negedge clk); idleCtl(); model[10] = 1'b1; check("R4 set direction", model);
    flagCmd = 3'd6; @(negedge clk); idleCtl();                   check("R4 code 6 no effect", model);
    flagCmd = 3'd7; @(negedge clk); idleCtl();                   check("R4 code 7 no effect", model);
    flagCmd = 3'd5; @(negedge clk); idleCtl(); model[10] = 1'b0; check("R4 clear direction", model);

    // R4: command overrides an operation that would clear everything
    flagCmd = 3'd1; opValid = 1'b1; opClass = 3'd4; opSize = 2'd0; opResult = 64'h0;
    @(negedge clk); idleCtl(); model[0] = 1'b1;
    check("R4 command beats operation", model);

    // R14: idle with busy data inputs
    srcA = 64'h1234; srcB = 64'h8888; opResult = 64'hFFFF_FFFF; shiftOut = 1'b1; wrData = '1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R14 idle hold", model);
    end

    // sweeps over class, size and operand patterns
    for (int cls = 0; cls < 8; cls++) begin
      for (int size = 0; size < 4; size++) begin
        for (int it = 0; it < 20; it++) begin
          int w;
          logic [63:0] m, a, b, r;
          logic so, multi;
          w = 8 << size;
          m = sizeMaskOf(w);
          if (it < 6) begin
            a = corner(it, m); b = corner((it + 3) % 6, m);
          end else if (it < 12) begin
            a = corner(it - 6, m); b = corner(it - 6, m);
          end else begin
            a = {$urandom, $urandom}; b = {$urandom, $urandom};
          end
          so = 1'b0; multi = 1'b0;
          case (cls)
            0: r = (a + b) & m;
            1, 5: r = (a - b) & m;
            2: begin b = 64'd1; r = (a + 64'd1) & m; end
            3: begin b = 64'd1; r = (a - 64'd1) & m; end
            4: r = (it % 3 == 0) ? (a & b) & m : ((it % 3 == 1) ? (a | b) & m : (a ^ b) & m);
            6: begin
              multi = (it % 2 == 1);
              if (multi) begin r = (a << 3) & m; so = a[w-3]; end
              else       begin r = (a << 1) & m; so = a[w-1]; end
            end
            default: r = {$urandom, $urandom};
          endcase
          runOp(cls, size, a, b, r, so, multi, reqOf(cls));
        end
      end
    end

    // R8: parity looks only at the low byte
    runOp(4, 3, 64'h0, 64'h0, 64'hFF00_0000_0000_0003, 1'b0, 1'b0, "R8 even low byte");
    runOp(4, 3, 64'h0, 64'h0, 64'h0000_0000_0001_0007, 1'b0, 1'b0, "R8 odd low byte");
    // R10: zero judged within size only
    runOp(4, 0, 64'h0, 64'h0, 64'h0000_0000_0000_0100, 1'b0, 1'b0, "R10 zero byte-size");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule